// File: doc/BRIEF.md
# Sector Disk Controller with DMA

This block sits behind a 32-bit register port and fronts a small block store made of fixed 512-byte sectors, numbered linearly from zero. Software programs a 36-bit buffer address (split over two registers), picks a sector, and then writes a command word. The controller copies that one sector between its local store and system memory. It does this over a word-wide master port that asks for every access with a request and waits for a grant. When the copy is done it raises an interrupt.

The same command word starts a transfer in either direction and also acknowledges the interrupt. The status register shows busy, error and interrupt-pending as three separate bits. A malformed command starts nothing and only sets the error bit. Malformed means both directions at once, or a sector past the end of the device. The device size, in bytes, can be read as two 32-bit halves.

Top module: `blkdma_ctrl`

## Requirements
- R1: After reset the buffer-address, sector and status registers read zero, `irq` is low and `dma_req` is low.
- R2: Byte offset 0 holds buffer address bits 31:0 and offset 16 holds bits 35:32 in its low 4 bits. Both read back what was written, and the upper 28 bits of offset 16 read zero.
- R3: Offset 4 holds the sector number used by the next transfer command, and it reads back as written.
- R4: Offsets 12 and 24 return the low and high 32 bits of the device size, which is NUM_SECTORS × 512 bytes. Writes to them are ignored. Offset 20 reads zero and ignores writes.
- R5: Writing offset 8 with bit 0 set (store to memory) copies the selected sector out. This takes 128 master writes (`dma_we`=1) to addresses base, base+4, … base+508, carrying the sector's words in order.
- R6: Writing offset 8 with bit 1 set (memory to store) copies a sector in. This takes 128 master reads (`dma_we`=0) at the same address sequence, and the words land in the selected sector.
- R7: While `dma_req` is high and `dma_gnt` is low, `dma_req`, `dma_addr`, `dma_we` and `dma_wdata` hold their values into the next cycle.
- R8: Status bit 4 (busy) reads 1 from the cycle after a command is accepted until the last word has been granted. A read or write command written while busy is ignored, and no extra transfer follows.
- R9: On the last granted word, busy clears and status bit 2 (pending) sets in the same cycle. `irq` follows the pending bit.
- R10: Writing offset 8 with bit 2 set clears pending and drops `irq`. This works while busy too.
- R11: A command with bits 0 and 1 both set, written while idle, starts no transfer and sets status bit 3 (error).
- R12: A read or write command whose sector number is NUM_SECTORS or above starts no transfer and sets the error bit.
- R13: An accepted read or write command clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = register write, 0 = read |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| dma_req | output | 1 | Master access request |
| dma_we | output | 1 | 1 = memory write, 0 = memory read |
| dma_addr | output | 36 | Master byte address |
| dma_wdata | output | 32 | Data for memory writes |
| dma_gnt | input | 1 | Grant; the access completes on the edge where it is high |
| dma_rdata | input | 32 | Memory read data, valid in the granted cycle |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Every sector is first filled from memory with random data. Transfers then run in random directions, to random sectors, at random 36-bit bases, with the grant withheld at random. This separates address stepping and data ordering from the effect of stalls, and it catches a store that mixes up sectors. Directed cases cover the remaining corners. A command written while busy, and an acknowledge written while busy, show that command gating and acknowledge are independent. Conflicting direction bits and out-of-range sectors (one past the end, and all ones) show that the error is raised without any master traffic, and the accepted command that follows shows that the error clears again.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  localparam int WORD_W         = 32;
  localparam int SECTOR_BYTES   = 512;
  localparam int WORDS_PER_SEC  = SECTOR_BYTES / (WORD_W / 8);
  localparam int ADDR_HI_W      = 4;
  localparam int DMA_AW         = WORD_W + ADDR_HI_W;
  localparam int REG_AW         = 5;

  localparam logic [REG_AW-1:0] OFS_BUF_LO  = 5'd0;
  localparam logic [REG_AW-1:0] OFS_SECTOR  = 5'd4;
  localparam logic [REG_AW-1:0] OFS_CMD     = 5'd8;
  localparam logic [REG_AW-1:0] OFS_SIZE_LO = 5'd12;
  localparam logic [REG_AW-1:0] OFS_BUF_HI  = 5'd16;
  localparam logic [REG_AW-1:0] OFS_SIZE_HI = 5'd24;

  localparam int CMD_TO_MEM_BIT = 0;
  localparam int CMD_TO_STO_BIT = 1;
  localparam int CMD_ACK_BIT    = 2;

  typedef enum logic {SEQ_IDLE, SEQ_MOVE} seq_state_e;
endpackage

// File: rtl/blkdma_store.sv
module blkdma_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int NUM_SECTORS = 4,
  localparam int SEC_IDX_W  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int IDX_W      = $clog2(WORDS_PER_SEC),
  localparam int DEPTH      = NUM_SECTORS * WORDS_PER_SEC,
  localparam int STA_W      = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_to_mem,
  input  logic [DMA_AW-1:0]    start_base,
  input  logic [SEC_IDX_W-1:0] start_sector,
  output logic                 busy,
  output logic                 xfer_done,
  output logic                 dma_req,
  output logic                 dma_we,
  output logic [DMA_AW-1:0]    dma_addr,
  output logic [WORD_W-1:0]    dma_wdata,
  input  logic                 dma_gnt,
  input  logic [WORD_W-1:0]    dma_rdata,
  output logic                 st_we,
  output logic [STA_W-1:0]     st_addr,
  output logic [WORD_W-1:0]    st_wdata,
  input  logic [WORD_W-1:0]    st_rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS_PER_SEC - 1);

  seq_state_e           state_q, state_d;
  logic                 dir_q, dir_d;
  logic [SEC_IDX_W-1:0] sec_q, sec_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DMA_AW-1:0]    addr_q, addr_d;
  logic                 beat;

  always_comb begin
    beat      = (state_q == SEQ_MOVE) && dma_gnt;
    xfer_done = beat && (idx_q == LAST_IDX);
    busy      = (state_q == SEQ_MOVE);
    dma_req   = busy;
    dma_we    = dir_q;
    dma_addr  = addr_q;
    dma_wdata = st_rdata;
    st_addr   = STA_W'(sec_q) * STA_W'(WORDS_PER_SEC) + STA_W'(idx_q);
    st_we     = beat && !dir_q;
    st_wdata  = dma_rdata;

    state_d = state_q;
    dir_d   = dir_q;
    sec_d   = sec_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    if (state_q == SEQ_IDLE) begin
      if (start) begin
        state_d = SEQ_MOVE;
        dir_d   = start_to_mem;
        sec_d   = start_sector;
        idx_d   = '0;
        addr_d  = start_base;
      end
    end else if (beat) begin
      idx_d  = idx_q + 1'b1;
      addr_d = addr_q + DMA_AW'(WORD_W / 8);
      if (idx_q == LAST_IDX) state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dir_q   <= 1'b0;
      sec_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      sec_q   <= sec_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
    end
  end
endmodule

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
#(
  parameter int NUM_SECTORS = 4,
  localparam int SEC_IDX_W  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 busy,
  input  logic                 xfer_done,
  output logic                 start,
  output logic                 start_to_mem,
  output logic [DMA_AW-1:0]    start_base,
  output logic [SEC_IDX_W-1:0] start_sector,
  output logic                 irq
);
  localparam logic [WORD_W-1:0]   SEC_LIMIT = WORD_W'(NUM_SECTORS);
  localparam logic [2*WORD_W-1:0] DEV_BYTES =
    (2*WORD_W)'(NUM_SECTORS) * (2*WORD_W)'(SECTOR_BYTES);

  logic [WORD_W-1:0]    buf_lo_q, sector_q;
  logic [ADDR_HI_W-1:0] buf_hi_q;
  logic                 err_q, err_d, pend_q, pend_d;
  logic                 wr_en, lo_en, hi_en, sec_en, cmd_wr;
  logic                 want_mem, want_sto, cmd_new, in_range;

  always_comb begin
    wr_en    = reg_sel && reg_we;
    lo_en    = wr_en && (reg_addr == OFS_BUF_LO);
    hi_en    = wr_en && (reg_addr == OFS_BUF_HI);
    sec_en   = wr_en && (reg_addr == OFS_SECTOR);
    cmd_wr   = wr_en && (reg_addr == OFS_CMD);
    want_mem = reg_wdata[CMD_TO_MEM_BIT];
    want_sto = reg_wdata[CMD_TO_STO_BIT];
    cmd_new  = cmd_wr && (want_mem || want_sto) && !busy;
    in_range = sector_q < SEC_LIMIT;
    start    = cmd_new && !(want_mem && want_sto) && in_range;
    start_to_mem = want_mem;
    start_base   = {buf_hi_q, buf_lo_q};
    start_sector = sector_q[SEC_IDX_W-1:0];

    err_d = cmd_new ? !start : err_q;
    pend_d = pend_q;
    if (cmd_wr && reg_wdata[CMD_ACK_BIT]) pend_d = 1'b0;
    if (xfer_done) pend_d = 1'b1;

    case (reg_addr)
      OFS_BUF_LO:  reg_rdata = buf_lo_q;
      OFS_SECTOR:  reg_rdata = sector_q;
      OFS_CMD:     reg_rdata = {27'd0, busy, err_q, pend_q, 2'b00};
      OFS_SIZE_LO: reg_rdata = DEV_BYTES[WORD_W-1:0];
      OFS_BUF_HI:  reg_rdata = {{(WORD_W-ADDR_HI_W){1'b0}}, buf_hi_q};
      OFS_SIZE_HI: reg_rdata = DEV_BYTES[2*WORD_W-1:WORD_W];
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_lo_q <= '0;
      buf_hi_q <= '0;
      sector_q <= '0;
      err_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (lo_en)  buf_lo_q <= reg_wdata;
      if (hi_en)  buf_hi_q <= reg_wdata[ADDR_HI_W-1:0];
      if (sec_en) sector_q <= reg_wdata;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
#(
  parameter int NUM_SECTORS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dma_req,
  output logic              dma_we,
  output logic [35:0]       dma_addr,
  output logic [31:0]       dma_wdata,
  input  logic              dma_gnt,
  input  logic [31:0]       dma_rdata,
  output logic              irq
);
  localparam int SEC_IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
  localparam int DEPTH     = NUM_SECTORS * WORDS_PER_SEC;
  localparam int STA_W     = $clog2(DEPTH);

  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  logic                 busy, xfer_done, start, start_to_mem;
  logic [DMA_AW-1:0]    start_base;
  logic [SEC_IDX_W-1:0] start_sector;
  logic                 st_we;
  logic [STA_W-1:0]     st_addr;
  logic [WORD_W-1:0]    st_wdata, st_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  blkdma_regs #(.NUM_SECTORS(NUM_SECTORS)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .xfer_done(xfer_done),
    .start(start), .start_to_mem(start_to_mem),
    .start_base(start_base), .start_sector(start_sector), .irq(irq)
  );

  blkdma_seq #(.NUM_SECTORS(NUM_SECTORS)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .start(start), .start_to_mem(start_to_mem),
    .start_base(start_base), .start_sector(start_sector),
    .busy(busy), .xfer_done(xfer_done),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_gnt(dma_gnt), .dma_rdata(dma_rdata),
    .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  blkdma_store #(.DEPTH(DEPTH), .DW(WORD_W)) u_store (
    .clk(clk), .wr_en(st_we), .addr(st_addr),
    .wdata(st_wdata), .rdata(st_rdata)
  );
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        xfer_done,
  input logic        irq,
  input logic        dma_req,
  input logic        dma_gnt,
  input logic        dma_we,
  input logic [35:0] dma_addr,
  input logic [31:0] dma_wdata,
  input logic        reg_sel,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata
);
  logic cmd_wr;
  assign cmd_wr = reg_sel && reg_we && (reg_addr == 5'd8);

  a_r7_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_gnt |=> dma_req && $stable(dma_addr) && $stable(dma_we) && $stable(dma_wdata));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_gnt && !xfer_done |=> dma_req && (dma_addr == $past(dma_addr) + 36'd4));

  a_r9_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq && !busy);

  a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dma_req);

  a_r10_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata[2] && !xfer_done |=> !irq);

  a_r11_conflict_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (reg_wdata[1:0] == 2'b11) && !busy |=> !busy);
endmodule

bind blkdma_ctrl blkdma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .xfer_done(xfer_done), .irq(irq),
  .dma_req(dma_req), .dma_gnt(dma_gnt), .dma_we(dma_we),
  .dma_addr(dma_addr), .dma_wdata(dma_wdata),
  .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/blkdma_ctrl_test.sv
`timescale 1ns/1ps
module blkdma_ctrl_test;
  localparam int NS  = 4;
  localparam int WPS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_req, dma_we, irq;
  logic [35:0] dma_addr;
  logic [31:0] dma_wdata;
  logic        dma_gnt = 1'b0;
  logic [31:0] dma_rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] bmem   [1024];
  logic [31:0] smodel [NS][WPS];
  int          beats;
  logic [35:0] exp_base;
  bit          exp_we;
  int          exp_sec;

  always #2.5 clk = ~clk;

  blkdma_ctrl #(.NUM_SECTORS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_gnt(dma_gnt), .dma_rdata(dma_rdata), .irq(irq)
  );

  function automatic int widx(logic [35:0] a);
    return int'(a[11:2]);
  endfunction

  function automatic logic [35:0] word_addr(logic [35:0] base, int k);
    return base + 36'(4 * k);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder: decides grants at negedges, records granted beats.
  initial begin
    bit          prev_req = 0, prev_gnt = 0;
    logic [35:0] prev_addr = '0;
    logic [31:0] prev_wdata = '0;
    bit          prev_we = 0;
    forever begin
      @(negedge clk);
      if (prev_req && !prev_gnt && dma_req)
        if (dma_addr !== prev_addr || dma_we !== prev_we || (dma_we && dma_wdata !== prev_wdata))
          chk("R7 hold", {dma_addr, dma_we}, {prev_addr, prev_we});
      if (dma_req) begin
        dma_gnt   = ($urandom % 4) != 0;
        dma_rdata = bmem[widx(dma_addr)];
        if (dma_gnt) begin
          chk("R5/R6 beat address", dma_addr, word_addr(exp_base, beats));
          chk("R5/R6 beat direction", dma_we, exp_we);
          if (dma_we) begin
            if (beats < WPS)
              chk("R5 word data", dma_wdata, smodel[exp_sec][beats]);
            bmem[widx(dma_addr)] = dma_wdata;
          end
          beats++;
        end
      end else begin
        dma_gnt = 1'b0;
      end
      prev_req = dma_req; prev_gnt = dma_gnt;
      prev_addr = dma_addr; prev_we = dma_we; prev_wdata = dma_wdata;
    end
  end

  task automatic reg_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic launch(bit to_mem, int sec, logic [35:0] base);
    logic [31:0] st;
    exp_base = base; exp_we = to_mem; exp_sec = sec; beats = 0;
    if (!to_mem)
      for (int k = 0; k < WPS; k++) bmem[widx(word_addr(base, k))] = $urandom;
    reg_wr(5'd0, base[31:0]);
    reg_wr(5'd16, {28'd0, base[35:32]});
    reg_wr(5'd4, 32'(sec));
    reg_wr(5'd8, to_mem ? 32'h1 : 32'h2);
    reg_rd(5'd8, st);
    chk("R8/R13 busy after accept", st & 32'h18, 32'h10);
  endtask

  task automatic finish_xfer();
    logic [31:0] st;
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk("R9 irq on completion", irq, 1'b1);
    reg_rd(5'd8, st);
    chk("R9 status after completion", st & 32'h14, 32'h4);
    chk("R5/R6 beat count", beats, WPS);
    for (int k = 0; k < WPS; k++) begin
      if (exp_we) begin
        if (bmem[widx(word_addr(exp_base, k))] !== smodel[exp_sec][k])
          chk("R5 memory contents", bmem[widx(word_addr(exp_base, k))], smodel[exp_sec][k]);
      end else begin
        smodel[exp_sec][k] = bmem[widx(word_addr(exp_base, k))];
      end
    end
  endtask

  task automatic ack_and_idle();
    logic [31:0] st;
    reg_wr(5'd8, 32'h4);
    reg_rd(5'd8, st);
    chk("R10 status after ack", st, 32'h0);
    chk("R10 irq after ack", irq, 1'b0);
  endtask

  task automatic expect_no_traffic(string tag);
    int b0 = beats;
    bit seen = 0;
    repeat (12) begin @(negedge clk); if (dma_req) seen = 1; end
    chk(tag, {seen, 32'(beats - b0)}, 33'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [35:0] base;
    void'($urandom(32'h5EC7_0001));
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    exp_base = '0; exp_we = 0; exp_sec = 0; beats = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_rd(5'd0, d);  chk("R1 buffer low", d, 0);
    reg_rd(5'd4, d);  chk("R1 sector", d, 0);
    reg_rd(5'd8, d);  chk("R1 status", d, 0);
    reg_rd(5'd16, d); chk("R1 buffer high", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);

    // R2 / R3 readback
    reg_wr(5'd0, 32'hDEAD_BEEC); reg_rd(5'd0, d); chk("R2 buffer low", d, 32'hDEAD_BEEC);
    reg_wr(5'd16, 32'hFFFF_FFFF); reg_rd(5'd16, d); chk("R2 buffer high 4 bits", d, 32'hF);
    reg_wr(5'd4, 32'h1234_5678); reg_rd(5'd4, d); chk("R3 sector", d, 32'h1234_5678);

    // R4 size and reserved
    reg_rd(5'd12, d); chk("R4 size low", d, NS * 512);
    reg_rd(5'd24, d); chk("R4 size high", d, 0);
    reg_wr(5'd12, 32'h0BAD_0BAD); reg_rd(5'd12, d); chk("R4 size low write ignored", d, NS * 512);
    reg_wr(5'd24, 32'h0BAD_0BAD); reg_rd(5'd24, d); chk("R4 size high write ignored", d, 0);
    reg_wr(5'd20, 32'h0BAD_0BAD); reg_rd(5'd20, d); chk("R4 reserved reads zero", d, 0);

    // R6 fill every sector from memory
    for (int s = 0; s < NS; s++) begin
      base = {4'(s), 32'h0000_1000 * (s + 1)};
      launch(1'b0, s, base);
      finish_xfer();
      ack_and_idle();
    end

    // R5 copy sectors out, random bases
    for (int s = NS - 1; s >= 0; s--) begin
      base = {4'($urandom), $urandom & 32'hFFFF_FFFC};
      launch(1'b1, s, base);
      finish_xfer();
      ack_and_idle();
    end

    // R8 command while busy is ignored
    launch(1'b1, 2, 36'h3_0000_0400);
    reg_wr(5'd8, 32'h2);
    reg_wr(5'd8, 32'h3);
    finish_xfer();
    reg_rd(5'd8, d); chk("R8 busy-time conflict left no error", d & 32'h8, 0);
    ack_and_idle();
    expect_no_traffic("R8 no extra transfer");

    // R10 acknowledge while busy
    launch(1'b0, 1, 36'h0_0000_2000);
    finish_xfer();
    launch(1'b1, 1, 36'h7_8000_0000);
    reg_rd(5'd8, d); chk("R9 pending kept across new command", d, 32'h14);
    reg_wr(5'd8, 32'h4);
    reg_rd(5'd8, d); chk("R10 ack during busy", d, 32'h10);
    chk("R10 irq low during busy", irq, 0);
    finish_xfer();
    ack_and_idle();

    // R11 both direction bits
    reg_wr(5'd4, 32'd0);
    reg_wr(5'd8, 32'h3);
    reg_rd(5'd8, d); chk("R11 conflict sets error", d, 32'h8);
    expect_no_traffic("R11 no transfer");

    // R13 accepted command clears error
    launch(1'b1, 0, 36'h1_0000_0000);
    finish_xfer();
    ack_and_idle();

    // R12 out-of-range sectors
    reg_wr(5'd4, 32'(NS));
    reg_wr(5'd8, 32'h1);
    reg_rd(5'd8, d); chk("R12 sector == capacity", d, 32'h8);
    expect_no_traffic("R12 no transfer at capacity");
    reg_wr(5'd4, 32'hFFFF_FFFF);
    reg_wr(5'd8, 32'h2);
    reg_rd(5'd8, d); chk("R12 sector all ones", d, 32'h8);
    expect_no_traffic("R12 no transfer at all ones");

    // Random mix
    for (int i = 0; i < 8; i++) begin
      base = {4'($urandom), $urandom & 32'hFFFF_FFFC};
      launch(1'($urandom), int'($urandom % NS), base);
      finish_xfer();
      ack_and_idle();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule